// File: doc/BRIEF.md
# Banked Glitchless Clock Output Enable

This block gates the clock outputs of a multi-bank clock generator. There are four output banks. Each bank receives its own source clock and drives two copies of that clock. Each bank has an active-low enable, and a single active-low master enable can shut every bank at once, whatever the bank enables say. A bank that is off holds both of its outputs at a steady low level.

A bank starts and stops only on whole clock pulses. The effective enable for a bank is brought into that bank's own clock domain through a two-flop synchronizer. It is then captured on the falling edge of the bank clock and ANDed with the clock. The output can therefore only change state during a low phase of its clock, and every high pulse that reaches a pin has the full width of the source. Reset closes every bank, and each bank stays closed until its synchronizer has refilled.

Top module: `banked_clk_gate`

## Requirements
- R1: Bank b (A=0, B=1, C=2, D=3) drives `clk_out[2b]` and `clk_out[2b+1]`. It copies `bank_clk[b]` while `bank_oe_n[b]` is 0 and `all_oe_n` is 0.
- R2: While `all_oe_n` is 1, every output is off, whatever the bank enables are.
- R3: An output whose bank is off stays at a constant 0, with no pulses.
- R4: The enable takes a fixed number of bank-clock edges to take effect. Suppose the effective enable of a bank changes during a low phase of its clock. Then the outputs keep their old behaviour for the next two high phases and take the new behaviour from the third high phase on.
- R5: No output ever shows a high pulse shorter than the high phase of its bank clock. No output shows a low gap shorter than the low phase of its bank clock, including across starts and stops.
- R6: The two outputs of a bank are equal at all times.
- R7: While `rst_n` is 0, all outputs are 0. After `rst_n` rises, the first two high phases of each bank clock are suppressed even with the enables active.
- R8: Each bank is enabled and disabled independently; the setting of one bank does not affect any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all banks |
| bank_clk | input | 4 | Source clock of each bank, index = bank |
| bank_oe_n | input | 4 | Active-low enable of each bank |
| all_oe_n | input | 1 | Active-low master enable for all banks |
| clk_out | output | 8 | Gated clocks, two per bank, bank b on bits 2b and 2b+1 |

## Verification
A wrong internal state shows up at the pins within one bank-clock period. A stuck synchronizer stage or capture flop leaves an output dead or free-running against the expected enable pattern. If the capture stage sampled on the wrong edge, the output would switch in the middle of a high phase, and the pulse-width monitor would report the shortened pulse at the next falling edge. A latency error of one stage moves the first or last output pulse by a whole period. The directed start and stop sequences on bank A, counted edge by edge, catch this.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned LANES_PER_BANK = 2;

  // Combined active-high open request from the two active-low enables.
  function automatic logic open_request(input logic all_off_n, input logic bank_off_n);
    return ~(all_off_n | bank_off_n);
  endfunction

  // Output pin index of a lane within a bank.
  function automatic int unsigned pin_index(input int unsigned bank,
                                            input int unsigned lane,
                                            input int unsigned lanes);
    return bank * lanes + lane;
  endfunction
endpackage

// File: rtl/en_sync2.sv
`timescale 1ns/1ps
module en_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;

  // R4
  sync_rise_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(d, 2));
  // R4
  sync_fall_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q) |-> !$past(d, 2));
endmodule

// File: rtl/lowphase_gate.sv
`timescale 1ns/1ps
module lowphase_gate #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [LANES-1:0] gclk
);
  // Enable captured only on the falling edge: it settles while clk is low.
  logic open_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= en;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign gclk[l] = clk & open_q;

    // R5: a high phase just ending was passed whole exactly when the stage was open
    full_phase_chk: assert property (@(negedge clk) disable iff (!rst_n)
      gclk[l] == open_q);
  end
endmodule

// File: rtl/banked_clk_gate.sv
`timescale 1ns/1ps
module banked_clk_gate
  import clkgate_pkg::*;
#(
  parameter int unsigned BANKS = NUM_BANKS,
  parameter int unsigned LANES = LANES_PER_BANK
) (
  input  logic                   rst_n,
  input  logic [BANKS-1:0]       bank_clk,
  input  logic [BANKS-1:0]       bank_oe_n,
  input  logic                   all_oe_n,
  output logic [BANKS*LANES-1:0] clk_out
);
  localparam int unsigned PINS = BANKS * LANES;

  logic [BANKS-1:0] open_req;
  logic [BANKS-1:0] open_sync;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LANES-1:0] lane_clk;

    assign open_req[b] = open_request(all_oe_n, bank_oe_n[b]);

    en_sync2 u_sync (
      .clk  (bank_clk[b]),
      .rst_n(rst_n),
      .d    (open_req[b]),
      .q    (open_sync[b])
    );

    lowphase_gate #(.LANES(LANES)) u_gate (
      .clk  (bank_clk[b]),
      .rst_n(rst_n),
      .en   (open_sync[b]),
      .gclk (lane_clk)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_pin
      assign clk_out[pin_index(b, l, LANES)] = lane_clk[l];
    end

    // R1
    bank_off_closes_chk: assert property (@(posedge bank_clk[b]) disable iff (!rst_n)
      $past(bank_oe_n[b]) |=> !open_sync[b]);
    // R2
    master_off_closes_chk: assert property (@(posedge bank_clk[b]) disable iff (!rst_n)
      $past(all_oe_n) |=> !open_sync[b]);

    // R6
    always_comb begin
      lanes_equal_chk: assert ((&lane_clk) || !(|lane_clk));
    end
  end

  // R7
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (clk_out == {PINS{1'b0}});
    end
  end
endmodule

// File: tb/banked_clk_gate_test.sv
`timescale 1ns/1ps
module banked_clk_gate_test;
  logic clk = 1'b0, cb = 1'b0, cc = 1'b0, cd = 1'b0;
  logic rst_n;
  logic [3:0] bclk;
  logic [3:0] bank_oe_n;
  logic all_oe_n;
  logic [7:0] clk_out;
  int n_chk = 0, n_fail = 0, short_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;   // bank A, 50 MHz
  always #15 cb = ~cb;
  always #22 cc = ~cc;
  always #13 cd = ~cd;
  assign bclk = {cd, cc, cb, clk};

  banked_clk_gate uut (
    .rst_n(rst_n), .bank_clk(bclk), .bank_oe_n(bank_oe_n),
    .all_oe_n(all_oe_n), .clk_out(clk_out)
  );

  function automatic real half_of(int b);
    case (b)
      0: return 10.0;
      1: return 15.0;
      2: return 22.0;
      default: return 13.0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R5 pulse-width monitor on every output
  for (genvar g = 0; g < 8; g++) begin : mon
    real tr = -1.0, tf = -1.0;
    always @(posedge clk_out[g]) begin
      if (tf >= 0.0 && ($realtime - tf) < half_of(g / 2) - 0.01) short_cnt++;
      tr = $realtime;
    end
    always @(negedge clk_out[g]) begin
      if (tr >= 0.0 && ($realtime - tr) < half_of(g / 2) - 0.01) short_cnt++;
      tf = $realtime;
    end
  end

  // {all_oe_n, bank_oe_n[3:0], expected open mask[3:0]}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 4'b0000, 4'b1111},
    {1'b0, 4'b1111, 4'b0000},
    {1'b0, 4'b0101, 4'b1010},
    {1'b0, 4'b1010, 4'b0101},
    {1'b1, 4'b0000, 4'b0000},
    {1'b0, 4'b1110, 4'b0001},
    {1'b1, 4'b0110, 4'b0000},
    {1'b0, 4'b0111, 4'b1000}
  };

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int bad;
    rst_n = 1'b0; all_oe_n = 1'b0; bank_oe_n = 4'b0000;
    // R7: quiet during reset with enables active
    #0.5;
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      if (clk_out != 8'h00) bad++;
      #1;
    end
    check(bad == 0, "R7 outputs low in reset", bad, 0);

    // R7/R4: release right after a bank A falling edge
    @(negedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #5 check(clk_out[1:0] == 2'b00, "R7 first high phase suppressed", clk_out[1:0], 0);
    @(posedge clk); #5 check(clk_out[1:0] == 2'b00, "R7 second high phase suppressed", clk_out[1:0], 0);
    @(posedge clk); #5 check(clk_out[1:0] == 2'b11, "R4 third high phase passes", clk_out[1:0], 3);

    // R4: stop latency on bank A
    @(negedge clk); #2 bank_oe_n[0] = 1'b1;
    @(posedge clk); #5 check(clk_out[1:0] == 2'b11, "R4 stop: first phase still full", clk_out[1:0], 3);
    @(posedge clk); #5 check(clk_out[1:0] == 2'b11, "R4 stop: second phase still full", clk_out[1:0], 3);
    @(posedge clk); #5 check(clk_out[1:0] == 2'b00, "R4 stop: third phase blocked", clk_out[1:0], 0);

    // Table walk: R1 R2 R3 R6 R8
    for (int v = 0; v < 8; v++) begin
      int miss [8];
      int pair_bad [4];
      logic [3:0] exp_m;
      all_oe_n = VEC[v][8];
      bank_oe_n = VEC[v][7:4];
      exp_m = VEC[v][3:0];
      #300;
      @(posedge clk); #0.5;
      for (int k = 0; k < 8; k++) miss[k] = 0;
      for (int k = 0; k < 4; k++) pair_bad[k] = 0;
      for (int t = 0; t < 220; t++) begin
        for (int o = 0; o < 8; o++) begin
          if (clk_out[o] !== (exp_m[o/2] ? bclk[o/2] : 1'b0)) miss[o]++;
        end
        for (int b = 0; b < 4; b++) if (clk_out[2*b] !== clk_out[2*b+1]) pair_bad[b]++;
        #1;
      end
      for (int o = 0; o < 8; o++) begin
        if (exp_m[o/2]) check(miss[o] == 0, VEC[v][8] ? "R2 master" : "R1 R8 bank copies clock", miss[o], 0);
        else check(miss[o] == 0, VEC[v][8] ? "R2 R3 master off low" : "R3 R8 bank off low", miss[o], 0);
      end
      for (int b = 0; b < 4; b++) check(pair_bad[b] == 0, "R6 lanes equal", pair_bad[b], 0);
    end

    check(short_cnt == 0, "R5 no shortened pulse or gap", short_cnt, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule